// File: doc/BRIEF.md
# Motor Commutation Mode Timer

This block times the phases of a sensorless brushless motor drive. A free-running up-counter advances on a selectable clock-enable tick while the run bit is set. Three compare channels watch the count: the first marks the commutation instant, the second marks the start of the position-detection window, and the third marks the overflow point of the electrical step. Each channel fires one interrupt pulse and then disarms, so software must re-arm it for every step.

Motor events drive the counter directly. A position-detection pulse, an overload-protection pulse, a software command and a compare-3 match can each be allowed to clear the counter. Position detection, overload and software can each be allowed to copy the count into a capture register. When capture and clear happen together, the register holds the interval since the previous clear, which is the commutation period. A debug output repeats the raw interrupt pulses so that they can be seen on a pin without software delay.

Top module: `comm_mode_timer`

## Requirements
- R1: After reset the count, the captured value, the overflow flag, every interrupt pulse and the debug output are zero, and no channel is armed.
- R2: Control register (address 0) holds run in bit 0 and clock select in bit 1. While run is 1 the count rises by one on each clock where the selected tick input is high (`tick_a_i` when select is 0, `tick_b_i` when 1). While run is 0 the count holds.
- R3: When the count is all ones and a tick advances it, the count wraps to zero and the sticky overflow flag sets. Writing address 4 with bit 3 set clears the flag. A set in the same cycle wins.
- R4: Compare values live at addresses 1, 2 and 3. An armed channel whose compare value equals the count on a tick, while run is 1, drives its bit of `irq_o` high for exactly one cycle, one clock after the match.
- R5: Writing address 4 with bit i set (i = 0..2) arms channel i+1. A channel disarms when it fires and gives no further pulse until it is re-armed, even if its compare value is unchanged.
- R6: Every counter clear disarms all three channels. So does a control write that changes run from 1 to 0. Channels armed while run is 0 stay armed when run is set.
- R7: Capture enables in control bits 2 (overload), 3 (software) and 4 (position detection) pick which events copy the count into `cap_o`. A software capture is a write to address 5 with bit 0 set. Events whose enable is 0 leave `cap_o` unchanged.
- R8: Clear enables in control bits 5 (compare 3 match), 6 (overload), 7 (software) and 8 (position detection) pick which events set the count to zero. A software clear is a write to address 5 with bit 1 set. A clear overrides a tick in the same cycle.
- R9: When a capture and a clear occur in the same cycle, `cap_o` receives the count from before the clear.
- R10: With control bit 9 set, `dbg_o` equals `irq_o` in the same cycle. With bit 9 clear, `dbg_o` is zero.
- R11: `pos_det_i` and `ovl_i` pass through a two-flop synchroniser and a rising-edge detector. A rising input acts on the third clock edge after it is set up, and it acts only once however long the input stays high.
- R12: With compare-3 clearing enabled, the count reads zero after the clock edge on which channel 3 matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| pos_det_i | input | 1 | Position-detection event, asynchronous |
| ovl_i | input | 1 | Overload-protection event, asynchronous |
| tick_a_i | input | 1 | Count enable source A |
| tick_b_i | input | 1 | Count enable source B |
| cap_o | output | CNT_W | Captured count |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 3 | Compare interrupt pulses, bit 0 = channel 1 |
| dbg_o | output | 3 | Debug copy of the interrupt pulses |

## Verification
On every cycle the assertions check these properties: an interrupt comes only from a channel that was armed, and a channel that fired is no longer armed unless it was re-armed. A clear leaves the count at zero and removes every earlier arm. The count stays put when there is neither a tick nor a clear. Overflow only rises on an all-ones tick. Each synchronised event lasts a single cycle, and debug never shows a pulse that is absent from `irq_o`. Other properties need an exact history of writes and events, so only the directed scenarios can show them: the measured interval when capture and clear coincide, the selection of clock and trigger sources, the spacing of the compare pulses, and the rule that arming before run survives while clearing run invalidates the arms.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP2 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP3 = 3'd3;
  localparam logic [ADDR_W-1:0] A_ARM  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd5;

  localparam int NUM_CH = 3;
  localparam int CTRL_W = 10;
  localparam int OVF_CLR_BIT = 3;
  localparam int CMD_CAP_BIT = 0;
  localparam int CMD_RST_BIT = 1;

  // Field order follows the bit positions of the control word, MSB first.
  typedef struct packed {
    logic dbg;
    logic rst_pos;
    logic rst_sw;
    logic rst_ovl;
    logic rst_cmp3;
    logic cap_pos;
    logic cap_sw;
    logic cap_ovl;
    logic clk_sel;
    logic run;
  } ctrl_t;

  function automatic ctrl_t to_ctrl(input logic [CTRL_W-1:0] bits);
    return ctrl_t'(bits);
  endfunction
endpackage

// File: rtl/cmt_edge_sync.sv
module cmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic pulse_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], async_i};
  end

  assign pulse_o = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  output ctrl_t                         ctrl_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_o,
  output logic [NUM_CH-1:0]             arm_set_o,
  output logic                          ovf_clr_o,
  output logic                          cmd_cap_o,
  output logic                          cmd_rst_o,
  output logic                          run_clr_o
);
  ctrl_t ctrl_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;

  logic hit_ctrl, hit_arm, hit_cmd;
  assign hit_ctrl = wr_en && (wr_addr == A_CTRL);
  assign hit_arm  = wr_en && (wr_addr == A_ARM);
  assign hit_cmd  = wr_en && (wr_addr == A_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (hit_ctrl) ctrl_q <= to_ctrl(wr_data[CTRL_W-1:0]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MY_ADDR = A_CMP1 + ADDR_W'(c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cmp_q[c] <= '0;
      else if (wr_en && (wr_addr == MY_ADDR))  cmp_q[c] <= wr_data;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign cmp_o     = cmp_q;
  assign arm_set_o = hit_arm ? wr_data[NUM_CH-1:0] : '0;
  assign ovf_clr_o = hit_arm && wr_data[OVF_CLR_BIT];
  assign cmd_cap_o = hit_cmd && wr_data[CMD_CAP_BIT];
  assign cmd_rst_o = hit_cmd && wr_data[CMD_RST_BIT];
  assign run_clr_o = hit_ctrl && ctrl_q.run && !wr_data[0];
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             capture_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic tick, input logic clear);
    if (clear)     return '0;
    else if (tick) return cur + CNT_W'(1);
    else           return cur;
  endfunction

  function automatic logic wraps(
    input logic [CNT_W-1:0] cur, input logic tick, input logic clear);
    return tick && !clear && (cur == TOP);
  endfunction

  logic [CNT_W-1:0] cnt_q, cap_q;
  logic             ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, tick_i, clear_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ovf_q <= 1'b0;
    else if (wraps(cnt_q, tick_i, clear_i)) ovf_q <= 1'b1;
    else if (ovf_clr_i)                     ovf_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cap_q <= '0;
    else if (capture_i) cap_q <= cnt_q;
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/cmt_compare_ch.sv
module cmt_compare_ch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             arm_i,
  input  logic             disarm_i,
  output logic             match_o,
  output logic             armed_o,
  output logic             irq_o
);
  function automatic logic hits(
    input logic armed, input logic tick,
    input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] cmp);
    return armed && tick && (cnt == cmp);
  endfunction

  logic armed_q, irq_q;

  assign match_o = hits(armed_q, tick_i, cnt_i, cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    armed_q <= 1'b0;
    else if (arm_i)                armed_q <= 1'b1;
    else if (match_o || disarm_i)  armed_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= match_o;
  end

  assign armed_o = armed_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/comm_mode_timer.sv
module comm_mode_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             pos_det_i,
  input  logic             ovl_i,
  input  logic             tick_a_i,
  input  logic             tick_b_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             ovf_o,
  output logic [2:0]       irq_o,
  output logic [2:0]       dbg_o
);
  ctrl_t                        ctrl;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  logic [NUM_CH-1:0]            arm_set, armed, match;
  logic ovf_clr, cmd_cap, cmd_rst, run_clr;
  logic pos_evt, ovl_evt;
  logic tick, rst_evt, cap_evt, disarm;
  logic [CNT_W-1:0] cnt_q;

  cmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl), .cmp_o(cmp), .arm_set_o(arm_set),
    .ovf_clr_o(ovf_clr), .cmd_cap_o(cmd_cap), .cmd_rst_o(cmd_rst),
    .run_clr_o(run_clr)
  );

  cmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_pos (
    .clk(clk), .rst_n(rst_n), .async_i(pos_det_i), .pulse_o(pos_evt)
  );
  cmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ovl (
    .clk(clk), .rst_n(rst_n), .async_i(ovl_i), .pulse_o(ovl_evt)
  );

  assign tick    = ctrl.run && (ctrl.clk_sel ? tick_b_i : tick_a_i);
  assign rst_evt = (ctrl.rst_cmp3 && match[2]) || (ctrl.rst_ovl && ovl_evt)
                || (ctrl.rst_sw && cmd_rst)    || (ctrl.rst_pos && pos_evt);
  assign cap_evt = (ctrl.cap_ovl && ovl_evt) || (ctrl.cap_sw && cmd_cap)
                || (ctrl.cap_pos && pos_evt);
  assign disarm  = rst_evt || run_clr;

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .clear_i(rst_evt),
    .capture_i(cap_evt), .ovf_clr_i(ovf_clr), .cnt_o(cnt_q),
    .cap_o(cap_o), .ovf_o(ovf_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cmt_compare_ch #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_i(cnt_q),
      .cmp_i(cmp[c]), .arm_i(arm_set[c]), .disarm_i(disarm),
      .match_o(match[c]), .armed_o(armed[c]), .irq_o(irq_o[c])
    );
  end

  assign dbg_o = ctrl.dbg ? irq_o : 3'b000;
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             rst_evt,
  input logic             pos_evt,
  input logic             ovl_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [2:0]       armed,
  input logic [2:0]       arm_set,
  input logic [2:0]       irq_o,
  input logic [2:0]       dbg_o,
  input logic             ovf_o
);
  assert_irq_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~$past(armed)) == 3'b000);

  assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & armed & ~$past(arm_set)) == 3'b000);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (cnt_q == '0));

  assert_clear_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> ((armed & ~$past(arm_set)) == 3'b000));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !rst_evt) |=> $stable(cnt_q));

  assert_ovf_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> ($past(tick) && ($past(cnt_q) == {CNT_W{1'b1}})));

  assert_pos_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pos_evt |=> !pos_evt);

  assert_ovl_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_evt |=> !ovl_evt);

  assert_dbg_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_o & ~irq_o) == 3'b000);
endmodule

bind comm_mode_timer cmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rst_evt(rst_evt),
  .pos_evt(pos_evt), .ovl_evt(ovl_evt), .cnt_q(cnt_q), .armed(armed),
  .arm_set(arm_set), .irq_o(irq_o), .dbg_o(dbg_o), .ovf_o(ovf_o)
);

// File: tb/comm_mode_timer_test.sv
module comm_mode_timer_test;
  localparam int W = 10;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pos_det_i = 1'b0, ovl_i = 1'b0, tick_a_i = 1'b0, tick_b_i = 1'b0;
  logic [W-1:0] cap_o;
  logic ovf_o;
  logic [2:0] irq_o, dbg_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comm_mode_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pos_det_i(pos_det_i), .ovl_i(ovl_i),
    .tick_a_i(tick_a_i), .tick_b_i(tick_b_i), .cap_o(cap_o),
    .ovf_o(ovf_o), .irq_o(irq_o), .dbg_o(dbg_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sw_capture();
    wr(3'd5, 1);
  endtask

  task automatic pulse_pos(input int width);
    pos_det_i = 1'b1;
    repeat (width) @(negedge clk);
    pos_det_i = 1'b0;
  endtask

  task automatic pulse_ovl(input int width);
    ovl_i = 1'b1;
    repeat (width) @(negedge clk);
    ovl_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cap", int'(cap_o), 0);
    chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 dbg", int'(dbg_o), 0);
    wr(3'd0, 'h008);
    sw_capture();
    chk("R1 count", int'(cap_o), 0);
  endtask

  task automatic t_count();
    wr(3'd0, 'h089);
    wr(3'd5, 2);
    tick_a_i = 1'b1; repeat (5) @(negedge clk); tick_a_i = 1'b0;
    sw_capture();
    chk("R2 tick_a count", int'(cap_o), 5);
    tick_b_i = 1'b1; repeat (3) @(negedge clk); tick_b_i = 1'b0;
    sw_capture();
    chk("R2 unselected tick_b", int'(cap_o), 5);
    wr(3'd0, 'h08B);
    tick_b_i = 1'b1; repeat (4) @(negedge clk); tick_b_i = 1'b0;
    sw_capture();
    chk("R2 tick_b count", int'(cap_o), 9);
    wr(3'd0, 'h088);
    tick_a_i = 1'b1; tick_b_i = 1'b1;
    repeat (3) @(negedge clk);
    tick_a_i = 1'b0; tick_b_i = 1'b0;
    sw_capture();
    chk("R2 hold when stopped", int'(cap_o), 9);
  endtask

  task automatic t_cap_and_clear();
    wr(3'd5, 3);
    chk("R9 capture before clear", int'(cap_o), 9);
    sw_capture();
    chk("R8 software clear", int'(cap_o), 0);
  endtask

  task automatic t_compare();
    int c1 = 0, c2 = 0, c3 = 0, i1 = 0, i2 = 0, i3 = 0, dbg_bad = 0;
    wr(3'd1, 4); wr(3'd2, 6); wr(3'd3, 8);
    wr(3'd0, 'h289);
    wr(3'd5, 2);
    wr(3'd4, 7);
    tick_a_i = 1'b1;
    for (int i = 1; i <= 1100; i++) begin
      @(negedge clk);
      if (dbg_o !== irq_o) dbg_bad++;
      if (irq_o[0]) begin c1++; if (i1 == 0) i1 = i; end
      if (irq_o[1]) begin c2++; if (i2 == 0) i2 = i; end
      if (irq_o[2]) begin c3++; if (i3 == 0) i3 = i; end
    end
    chk("R4 first match cycle", i1, 5);
    chk("R4 ch2 after ch1", i2 - i1, 2);
    chk("R4 ch3 after ch2", i3 - i2, 2);
    chk("R5 ch1 one shot over wrap", c1, 1);
    chk("R5 ch2 one shot", c2, 1);
    chk("R5 ch3 one shot", c3, 1);
    chk("R10 dbg mirrors irq", dbg_bad, 0);
    wr(3'd0, 'h089);
    wr(3'd4, 1);
    c1 = 0; dbg_bad = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (irq_o[0]) c1++;
      if (dbg_o !== 3'b000) dbg_bad++;
    end
    chk("R5 rearm fires again", c1, 1);
    chk("R10 dbg quiet when off", dbg_bad, 0);
    tick_a_i = 1'b0;
  endtask

  task automatic t_cmp3_clear();
    int c1 = 0, c3 = 0;
    bit took = 1'b0;
    wr(3'd0, 'h0A9);
    wr(3'd5, 2);
    wr(3'd4, 5);
    tick_a_i = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq_o[0]) c1++;
      if (irq_o[2]) c3++;
      if (irq_o[2] && !took) begin
        took = 1'b1;
        sw_capture();
        chk("R12 count zero after ch3 match", int'(cap_o), 0);
      end
    end
    chk("R6 ch1 disarmed by clear", c1, 1);
    chk("R12 ch3 fired once", c3, 1);
    tick_a_i = 1'b0;
  endtask

  task automatic t_run_clear();
    int c1 = 0;
    wr(3'd0, 'h089);
    wr(3'd5, 2);
    wr(3'd1, 4);
    wr(3'd4, 1);
    wr(3'd0, 'h088);
    wr(3'd0, 'h089);
    tick_a_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_o[0]) c1++;
    end
    tick_a_i = 1'b0;
    chk("R6 stop disarms", c1, 0);
  endtask

  task automatic t_external();
    tick_a_i = 1'b1;
    wr(3'd0, 'h111);
    pulse_pos(2); repeat (18) @(negedge clk);
    pulse_pos(6); repeat (5) @(negedge clk);
    chk("R11 pos interval single trigger", int'(cap_o), 19);
    wr(3'd0, 'h045);
    pulse_ovl(2); repeat (13) @(negedge clk);
    pulse_ovl(3); repeat (5) @(negedge clk);
    chk("R7 ovl capture interval", int'(cap_o), 14);
    pulse_pos(2); repeat (5) @(negedge clk);
    chk("R7 pos ignored when not enabled", int'(cap_o), 14);
    tick_a_i = 1'b0;
  endtask

  task automatic t_overflow();
    wr(3'd0, 'h089);
    wr(3'd4, 8);
    chk("R3 flag cleared", int'(ovf_o), 0);
    wr(3'd5, 2);
    tick_a_i = 1'b1;
    repeat (1023) @(negedge clk);
    chk("R3 no flag before wrap", int'(ovf_o), 0);
    @(negedge clk);
    chk("R3 flag on wrap", int'(ovf_o), 1);
    sw_capture();
    chk("R3 wrapped to zero", int'(cap_o), 0);
    repeat (3) @(negedge clk);
    chk("R3 flag sticky", int'(ovf_o), 1);
    tick_a_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_cap_and_clear();
    t_compare();
    t_cmp3_clear();
    t_run_clear();
    t_external();
    t_overflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule